// File: doc/BRIEF.md
# Register Burst Access Sequencer

This block moves a short run of consecutive 32-bit words between a 64-entry register file and the one variable-latency operation that a clause may carry, such as a vector load or a vector store. Because a clause holds at most one such operation, a single start index from the clause header is enough to say which registers are meant. A request supplies that start index, a word count from 1 to 4 and a direction flag.

For a store, the block reads the registers one per cycle in ascending order and then presents all gathered words at once with a one-cycle valid flag. For a load, it waits for returned words on a valid/ready handshake, which may arrive long after the request, and writes each word to the next register in line. Before any access it checks whether the run stays inside the file. A run that would pass the last register is refused with a one-cycle fault pulse and touches nothing. Runs may begin at any index, with no alignment rule for pairs or quads.

Top module: `regburst_seq`

## Requirements
- R1: Out of reset, busy, fault, st_valid, rf_re, rf_we and ld_ready are all 0.
- R2: A request presented while busy is 1 is ignored. It produces no fault, no access and no later effect.
- R3: A request with req_len equal to 0 is ignored. busy and fault stay 0.
- R4: In the cycle after it is taken, a request with req_start + req_len - 1 > 63, or with req_len > 4, raises fault for exactly that one cycle. busy stays 0 and no register is read or written. For example, a 4-word load at index 63 changes no register.
- R5: Any start index from 0 to 63 is accepted as long as the run ends at or below 63, whatever its alignment.
- R6: A store (req_store = 1) asserts rf_re for req_len consecutive cycles, starting the cycle after acceptance. rf_raddr runs from req_start upward by 1 each cycle.
- R7: st_valid is 1 for exactly the one cycle after the last store read. st_data word i (bits 32i+31 down to 32i) holds register req_start+i, and words at or above req_len are 0.
- R8: A load (req_store = 0) holds ld_ready at 1 until its last word is taken. In each cycle where ld_valid and ld_ready are both 1, rf_we is 1 and ld_data is written to the next register, starting at req_start. rf_we is 0 in every other cycle.
- R9: busy is 1 from the cycle after acceptance until the cycle that performs the final access, and 0 in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_start | input | 6 | First register index |
| req_len | input | 3 | Number of words, 1 to 4 |
| req_store | input | 1 | 1 = read registers (store), 0 = write registers (load) |
| busy | output | 1 | Burst in progress |
| fault | output | 1 | One-cycle pulse: burst out of range |
| rf_re | output | 1 | Register read enable |
| rf_raddr | output | 6 | Register read index |
| rf_rdata | input | 32 | Register read data, same cycle |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 6 | Register write index |
| rf_wdata | output | 32 | Register write data |
| ld_valid | input | 1 | Returned load word valid |
| ld_ready | output | 1 | Ready for a returned load word |
| ld_data | input | 32 | Returned load word |
| st_valid | output | 1 | Gathered store data valid, one cycle |
| st_data | output | 128 | Gathered store words, word 0 lowest |

## Verification
The bench targets runs that end exactly on register 63 from unaligned starts (61 for 3 words, 60 for 4, 63 for 1), where an off-by-one bounds check would wrongly fault. It also sends runs one past the end, including 4 words at 63, where a missing check would wrap to register 0 or corrupt the top of the file. Loads are fed with gaps between returned words to catch a design that writes without a handshake or moves ahead on idle cycles. Zero-length requests and requests made while busy are sent to expose a sequencer that starts a spurious burst.

// File: rtl/regburst_seq.sv
module regburst_seq #(
  parameter int NREGS  = 64,
  parameter int DW     = 32,
  parameter int MAXLEN = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [$clog2(NREGS)-1:0] req_start,
  input  logic [$clog2(MAXLEN):0]  req_len,
  input  logic                   req_store,
  output logic                   busy,
  output logic                   fault,
  output logic                   rf_re,
  output logic [$clog2(NREGS)-1:0] rf_raddr,
  input  logic [DW-1:0]          rf_rdata,
  output logic                   rf_we,
  output logic [$clog2(NREGS)-1:0] rf_waddr,
  output logic [DW-1:0]          rf_wdata,
  input  logic                   ld_valid,
  output logic                   ld_ready,
  input  logic [DW-1:0]          ld_data,
  output logic                   st_valid,
  output logic [MAXLEN*DW-1:0]   st_data
);
  localparam int AW = $clog2(NREGS);
  localparam int LW = $clog2(MAXLEN) + 1;
  localparam int EW = AW + LW;
  localparam logic [EW-1:0] LAST_IX = EW'(NREGS - 1);

  typedef enum logic [1:0] {S_IDLE, S_STORE, S_LOAD} mode_t;

  mode_t                 mode;
  logic [AW-1:0]         addr;
  logic [LW-1:0]         left;
  logic [LW-1:0]         idx;
  logic [MAXLEN*DW-1:0]  gather;

  logic [EW-1:0] end_ix;
  logic          accept, bad;

  assign end_ix = {{LW{1'b0}}, req_start} + {{AW{1'b0}}, req_len} - 1'b1;
  assign accept = req_valid && mode == S_IDLE && req_len != '0;
  assign bad    = (req_len > LW'(MAXLEN)) || (end_ix > LAST_IX);

  assign busy     = mode != S_IDLE;
  assign rf_re    = mode == S_STORE;
  assign rf_raddr = addr;
  assign ld_ready = mode == S_LOAD;
  assign rf_we    = ld_ready && ld_valid;
  assign rf_waddr = addr;
  assign rf_wdata = ld_data;
  assign st_data  = gather;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= S_IDLE;
      addr     <= '0;
      left     <= '0;
      idx      <= '0;
      gather   <= '0;
      fault    <= 1'b0;
      st_valid <= 1'b0;
    end else begin
      fault    <= 1'b0;
      st_valid <= 1'b0;
      case (mode)
        S_IDLE: begin
          if (accept) begin
            if (bad) begin
              fault <= 1'b1;
            end else begin
              mode <= req_store ? S_STORE : S_LOAD;
              addr <= req_start;
              left <= req_len;
              idx  <= '0;
              if (req_store) gather <= '0;
            end
          end
        end
        S_STORE: begin
          gather[int'(idx)*DW +: DW] <= rf_rdata;
          addr <= addr + 1'b1;
          idx  <= idx + 1'b1;
          left <= left - 1'b1;
          if (left == LW'(1)) begin
            mode     <= S_IDLE;
            st_valid <= 1'b1;
          end
        end
        S_LOAD: begin
          if (ld_valid) begin
            addr <= addr + 1'b1;
            left <= left - 1'b1;
            if (left == LW'(1)) mode <= S_IDLE;
          end
        end
        default: mode <= S_IDLE;
      endcase
    end
  end
endmodule

module regburst_seq_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          fault,
  input logic          rf_re,
  input logic [AW-1:0] rf_raddr,
  input logic          rf_we,
  input logic          ld_valid,
  input logic          ld_ready,
  input logic          st_valid
);
  assert_fault_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!busy && !rf_re && !rf_we));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_re && $past(rf_re)) |-> (rf_raddr == $past(rf_raddr) + 1'b1));

  assert_single_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_re && rf_we));

  assert_stv_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> !st_valid);

  assert_write_handshake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (ld_valid && ld_ready));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rf_re && !ld_ready));
endmodule

bind regburst_seq regburst_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .fault(fault), .rf_re(rf_re),
  .rf_raddr(rf_raddr), .rf_we(rf_we), .ld_valid(ld_valid),
  .ld_ready(ld_ready), .st_valid(st_valid)
);

// File: tb/tb_regburst_seq.sv
module tb_regburst_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_store = 0, ld_valid = 0;
  logic [5:0] req_start = 0;
  logic [2:0] req_len = 0;
  logic [31:0] ld_data = 0;
  logic busy, fault, rf_re, rf_we, ld_ready, st_valid;
  logic [5:0] rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata;
  logic [127:0] st_data;

  logic [31:0] regs [64];
  logic [31:0] exp_regs [64];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regburst_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_start(req_start),
    .req_len(req_len), .req_store(req_store), .busy(busy), .fault(fault),
    .rf_re(rf_re), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_data(ld_data), .st_valid(st_valid), .st_data(st_data)
  );

  assign rf_rdata = regs[rf_raddr];
  always @(posedge clk) if (rf_we) regs[rf_waddr] <= rf_wdata;

  // reference model: 0 idle, 1 store, 2 load
  int m_mode = 0, m_addr = 0, m_left = 0, m_idx = 0;
  logic [127:0] m_buf = 0;
  bit m_fault = 0, m_stv = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_addr = 0; m_left = 0; m_idx = 0; m_buf = 0; m_fault = 0; m_stv = 0;
    end else begin
      m_fault = 0; m_stv = 0;
      if (m_mode == 0) begin
        if (req_valid && req_len != 0) begin
          if (req_len > 4 || int'(req_start) + int'(req_len) - 1 > 63) m_fault = 1;
          else begin
            m_mode = req_store ? 1 : 2; m_addr = req_start; m_left = req_len; m_idx = 0;
            if (req_store) m_buf = 0;
          end
        end
      end else if (m_mode == 1) begin
        m_buf[m_idx*32 +: 32] = regs[m_addr];
        m_addr++; m_idx++; m_left--;
        if (m_left == 0) begin m_mode = 0; m_stv = 1; end
      end else if (ld_valid) begin
        exp_regs[m_addr] = ld_data;
        m_addr++; m_left--;
        if (m_left == 0) m_mode = 0;
      end
    end
  end

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  initial forever begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && !finished) begin
      chk("R9 busy", busy, m_mode != 0);
      chk("R4 fault", fault, m_fault);
      chk("R6 rf_re", rf_re, m_mode == 1);
      if (m_mode == 1) chk("R6 rf_raddr", rf_raddr, m_addr);
      chk("R8 ld_ready", ld_ready, m_mode == 2);
      chk("R8 rf_we", rf_we, m_mode == 2 && ld_valid);
      if (m_mode == 2 && ld_valid) chk("R8 rf_waddr", rf_waddr, m_addr);
      chk("R7 st_valid", st_valid, m_stv);
      if (m_stv) chk("R7 st_data", st_data, m_buf);
    end
  end

  task automatic send(input int start, input int len, input bit store);
    @(negedge clk);
    req_valid = 1; req_start = 6'(start); req_len = 3'(len); req_store = store;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic feed(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) @(negedge clk);
      ld_valid = 1; ld_data = 32'hD000_0000 + 32'(i * 17 + gap);
      @(negedge clk);
      ld_valid = 0;
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic cmp_regs(string req);
    for (int i = 0; i < 64; i++) chk(req, regs[i], exp_regs[i]);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      regs[i] = 32'hA500_0000 + 32'(i) * 32'h0101;
      exp_regs[i] = regs[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", {busy, fault, st_valid, rf_re, rf_we, ld_ready}, 6'b0);

    send(5, 4, 1);  wait_idle();            // R6 R7 full quad, unaligned
    send(61, 3, 1); wait_idle();            // R5 ends at 63
    send(63, 1, 1); wait_idle();            // R5 single at top
    send(2, 2, 1);  wait_idle();            // R7 upper words zero

    send(10, 3, 0); feed(3, 2); wait_idle(); // R8 gaps
    cmp_regs("R8 load contents");
    send(60, 4, 0); feed(4, 0); wait_idle(); // R5 R8 quad to top
    cmp_regs("R5 load at top");

    send(63, 4, 0); feed(2, 0); wait_idle(); // R4 must write nothing
    cmp_regs("R4 no write on fault");
    send(62, 3, 1); wait_idle();             // R4
    send(0, 5, 1);  wait_idle();             // R4 length over 4
    chk("R4 idle after fault", busy, 1'b0);

    send(20, 0, 0); feed(1, 0); wait_idle(); // R3
    chk("R3 zero length ignored", busy, 1'b0);
    cmp_regs("R3 no write");

    send(30, 2, 0);                          // R2: second request while busy
    send(40, 1, 1);
    feed(2, 1); wait_idle();
    chk("R2 idle after one burst", {busy, rf_re}, 2'b0);
    cmp_regs("R2 contents");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule